// File: doc/BRIEF.md
# Sample Buffer Load and Playback Controller

This block holds one 16-bit stream control word and manages an on-chip sample memory. While loading is enabled, 16-bit words offered by the host side are stored at consecutive addresses, starting from zero. While playback is enabled and loading is off, the stored words are sent out again and again, in order, to the transmit data path. The same control word also drives the receive-stream enable, the receive source select and the receive channel select toward the host path.

The usual sequence is as follows. Software enables loading with playback and receive off and streams the samples in, in one burst or in several. It then writes a control value that turns loading off and playback on. The number of stored words is recorded at that write and sets the playback loop length. Both stream interfaces use valid/ready. A word moves when valid and ready are both high at a rising clock edge.

On the input, ready is high for as long as loading is enabled. When the memory is full, words are still accepted but are thrown away, and a sticky overflow flag is set. On the output, a valid word that has not been taken keeps its data and valid until ready is seen. Valid drops only when playback is switched off.

Top module: `sbuf_ctrl`

## Requirements
- R1: After reset the control word at address 0x0005 reads 0x0002. in_ready is 1, and pb_valid, rx_en and ovf_flag are 0.
- R2: A read at address 0x0005 returns the five control bits in bits 4..0, with bits 15..5 reading zero. A read at any other address returns zero, and writes to other addresses change nothing.
- R3: rx_en follows control bit 2, rx_src follows bit 3 and rx_chan follows bit 4, from the cycle after the register write.
- R4: in_ready is 1 exactly while control bit 0 is 0. Accepted words are stored at consecutive addresses, beginning at address 0.
- R5: A register write that takes bit 0 from 1 to 0 starts a new load. It returns the write address to zero and clears ovf_flag. Bursts that arrive while bit 0 stays 0 are appended to one another.
- R6: Once DEPTH words are stored, further accepted words are discarded. ovf_flag is then set and stays set until the next load start, and the stored words are unchanged.
- R7: The loop length is the number of words stored between the load start and the write that takes bit 0 from 0 to 1. This count includes a word accepted in the same cycle as that write.
- R8: While bit 0 is 1, bit 1 is 1 and the length is nonzero, pb_data delivers the stored words 0 to length-1 in order and repeats them without end.
- R9: While pb_valid is 1 and pb_ready is 0, pb_valid and pb_data hold their values into the next cycle.
- R10: pb_valid is 0 in any cycle where bit 0 is 0 or bit 1 is 0. Re-enabling playback restarts at word 0.
- R11: While bit 0 is 1, in_valid has no effect: in_ready is 0 and the stored words do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 15 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| in_valid | input | 1 | Load word offered |
| in_ready | output | 1 | Load word accepted when high with in_valid |
| in_data | input | 16 | Load word |
| pb_valid | output | 1 | Playback word available |
| pb_ready | input | 1 | Transmit path takes the playback word |
| pb_data | output | 16 | Playback word |
| rx_en | output | 1 | Receive stream enable |
| rx_src | output | 1 | Receive source select |
| rx_chan | output | 1 | Receive channel select |
| ovf_flag | output | 1 | Sticky flag: a word was dropped because the memory was full |

## Verification
The stop of a load and the acceptance of a data word can happen in the same cycle. The bench provokes this by offering a final word in the same clock as the register write that sets bit 0 and bit 1. That word must appear as the last entry of every playback loop, so a lost or double-counted word shows up as a mismatch in the played sequence. The same replay comparison judges the full-memory case, where words pushed past DEPTH must never appear.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
  localparam int DATA_W = 16;
  localparam int REG_AW = 15;
  localparam logic [REG_AW-1:0] CTRL_ADDR = 15'h0005;

  // Field order: bit 0 is the least significant member (load_off).
  typedef struct packed {
    logic chan;      // bit 4: receive channel select
    logic src;       // bit 3: receive source select
    logic rx_on;     // bit 2: receive stream enable
    logic play_on;   // bit 1: playback enable
    logic load_off;  // bit 0: loading disabled when 1
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
  localparam ctrl_t CTRL_RST = '{chan: 1'b0, src: 1'b0, rx_on: 1'b0,
                                 play_on: 1'b1, load_off: 1'b0};
endpackage

// File: rtl/sbuf_reg.sv
module sbuf_reg
  import sbuf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [REG_AW-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output ctrl_t             ctrl,
  output logic              load_start,
  output logic              load_stop
);
  logic  hit;
  ctrl_t nxt;
  logic  unused_wdata;

  assign hit          = wr && (addr == CTRL_ADDR);
  assign nxt          = ctrl_t'(wdata[CTRL_W-1:0]);
  assign unused_wdata = ^wdata[DATA_W-1:CTRL_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ctrl <= CTRL_RST;
    else if (hit) ctrl <= nxt;
  end

  // Edge strobes on the active-low load bit, seen in the write cycle
  assign load_start = hit &&  ctrl.load_off && !nxt.load_off;
  assign load_stop  = hit && !ctrl.load_off &&  nxt.load_off;

  assign rdata = (addr == CTRL_ADDR) ? {{(DATA_W-CTRL_W){1'b0}}, ctrl} : '0;
endmodule

// File: rtl/sbuf_wr.sv
module sbuf_wr #(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic              load_start,
  input  logic              load_stop,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              we,
  output logic [AW-1:0]     waddr,
  output logic [DATA_W-1:0] wdata,
  output logic [CW-1:0]     len,
  output logic              ovf
);
  logic [CW-1:0] count, cnt_nxt;
  logic          full, acc;

  assign in_ready = load_en;
  assign acc      = in_valid && in_ready;
  assign full     = (count == CW'(DEPTH));
  assign we       = acc && !full;
  assign waddr    = count[AW-1:0];
  assign wdata    = in_data;
  assign cnt_nxt  = we ? count + CW'(1) : count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      len   <= '0;
      ovf   <= 1'b0;
    end else begin
      if (load_start) begin
        count <= '0;
        ovf   <= 1'b0;
      end else begin
        count <= cnt_nxt;
        if (acc && full) ovf <= 1'b1;
      end
      // Includes a word accepted in the stop cycle
      if (load_stop) len <= cnt_nxt;
    end
  end
endmodule

// File: rtl/sbuf_rd.sv
module sbuf_rd #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          play_req,
  input  logic          load_off,
  input  logic [CW-1:0] len,
  input  logic          pb_ready,
  output logic          re,
  output logic [AW-1:0] raddr,
  output logic          pb_valid
);
  logic run, vld_q, last;

  assign run  = play_req && load_off && (|len);
  assign re   = run && (!vld_q || pb_ready);
  assign last = (CW'(raddr) == len - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raddr <= '0;
      vld_q <= 1'b0;
    end else if (!run) begin
      raddr <= '0;
      vld_q <= 1'b0;
    end else if (re) begin
      vld_q <= 1'b1;
      raddr <= last ? '0 : raddr + AW'(1);
    end
  end

  assign pb_valid = vld_q && run;
endmodule

// File: rtl/sbuf_ram.sv
module sbuf_ram #(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) q <= mem[raddr];
  end
endmodule

// File: rtl/sbuf_ctrl.sv
module sbuf_ctrl
  import sbuf_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              pb_valid,
  input  logic              pb_ready,
  output logic [DATA_W-1:0] pb_data,
  output logic              rx_en,
  output logic              rx_src,
  output logic              rx_chan,
  output logic              ovf_flag
);
  ctrl_t             ctrl;
  logic              load_start, load_stop;
  logic              we, re;
  logic [AW-1:0]     waddr, raddr;
  logic [DATA_W-1:0] wdata;
  logic [CW-1:0]     len;

  sbuf_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .ctrl(ctrl), .load_start(load_start), .load_stop(load_stop)
  );

  sbuf_wr #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .load_en(!ctrl.load_off), .load_start(load_start),
    .load_stop(load_stop), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .we(we), .waddr(waddr), .wdata(wdata), .len(len),
    .ovf(ovf_flag)
  );

  sbuf_rd #(.DEPTH(DEPTH)) u_rd (
    .clk(clk), .rst_n(rst_n), .play_req(ctrl.play_on), .load_off(ctrl.load_off),
    .len(len), .pb_ready(pb_ready), .re(re), .raddr(raddr), .pb_valid(pb_valid)
  );

  sbuf_ram #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
    .re(re), .raddr(raddr), .q(pb_data)
  );

  assign rx_en   = ctrl.rx_on;
  assign rx_src  = ctrl.src;
  assign rx_chan = ctrl.chan;
endmodule

// File: rtl/sbuf_ctrl_chk.sv
module sbuf_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [14:0] reg_addr,
  input logic [15:0] reg_wdata,
  input logic [15:0] reg_rdata,
  input logic        in_ready,
  input logic        pb_valid,
  input logic        pb_ready,
  input logic [15:0] pb_data,
  input logic        rx_en,
  input logic        rx_src,
  input logic        rx_chan,
  input logic        ovf_flag
);
  logic ctrl_wr;
  assign ctrl_wr = reg_wr && (reg_addr == 15'h0005);

  assert_rdata_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[15:5] == 11'd0) && ((reg_addr != 15'h0005) -> (reg_rdata == 16'd0)));

  assert_rx_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (rx_en == $past(reg_wdata[2]) && rx_src == $past(reg_wdata[3])
                 && rx_chan == $past(reg_wdata[4])));

  assert_stop_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && reg_wdata[0]) |=> !in_ready);

  assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !(ctrl_wr && !reg_wdata[0] && !in_ready)) |=> ovf_flag);

  assert_pb_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pb_valid && !pb_ready && !reg_wr) |=> (pb_valid && $stable(pb_data)));

  assert_no_play_in_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !pb_valid);
endmodule

bind sbuf_ctrl sbuf_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_ready(in_ready),
  .pb_valid(pb_valid), .pb_ready(pb_ready), .pb_data(pb_data),
  .rx_en(rx_en), .rx_src(rx_src), .rx_chan(rx_chan), .ovf_flag(ovf_flag)
);

// File: tb/sbuf_ctrl_tb.sv
module sbuf_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [14:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        pb_valid;
  logic        pb_ready = 1'b0;
  logic [15:0] pb_data;
  logic        rx_en, rx_src, rx_chan, ovf_flag;

  sbuf_ctrl #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .pb_valid(pb_valid),
    .pb_ready(pb_ready), .pb_data(pb_data), .rx_en(rx_en), .rx_src(rx_src),
    .rx_chan(rx_chan), .ovf_flag(ovf_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  // Bench model of stored words, count, loop length and control bits
  logic [15:0] mdl [DEPTH];
  int          mcnt = 0;
  int          mlen = 0;
  logic [4:0]  mctrl = 5'b00010;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  // One cycle with optional register write and optional input word
  task automatic cyc(input bit w, input logic [14:0] a, input logic [15:0] d,
                     input bit v, input logic [15:0] dat);
    reg_wr = w; reg_addr = a; reg_wdata = d;
    in_valid = v; in_data = dat;
    #1;
    if (v && in_ready) begin
      if (mcnt < DEPTH) begin
        mdl[mcnt] = dat;
        mcnt++;
      end
    end
    if (w && a == 15'h0005) begin
      if (mctrl[0] && !d[0]) mcnt = 0;
      if (!mctrl[0] && d[0]) mlen = mcnt;
      mctrl = d[4:0];
    end
    tick();
    reg_wr = 1'b0; in_valid = 1'b0;
  endtask

  task automatic wr_reg(input logic [14:0] a, input logic [15:0] d);
    cyc(1'b1, a, d, 1'b0, 16'h0);
  endtask

  task automatic push(input int n, input bit dense);
    for (int i = 0; i < n; i++)
      cyc(1'b0, 15'h0, 16'h0, dense ? 1'b1 : ($urandom % 3 != 0), 16'($urandom));
  endtask

  task automatic play_check(input int nw, input string req);
    int idx = 0;
    int guard = 0;
    bit prev_stall = 1'b0;
    logic [15:0] prev_d = '0;
    while (idx < nw && guard < nw * 8 + 20) begin
      pb_ready = ($urandom % 4 != 0);
      #1;
      if (prev_stall)
        chk(pb_valid && pb_data == prev_d, "R9 hold", int'(pb_data), int'(prev_d));
      if (pb_valid && pb_ready) begin
        chk(pb_data == mdl[idx % mlen], req, int'(pb_data), int'(mdl[idx % mlen]));
        idx++;
      end
      prev_stall = pb_valid && !pb_ready;
      prev_d = pb_data;
      guard++;
      tick();
    end
    pb_ready = 1'b0;
    chk(idx == nw, {req, " word count"}, idx, nw);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    reg_addr = 15'h0005; #1;
    chk(reg_rdata == 16'h0002, "R1 ctrl reset", int'(reg_rdata), 2);
    chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
    chk(pb_valid == 1'b0, "R1 pb_valid", int'(pb_valid), 0);
    chk(rx_en == 1'b0 && ovf_flag == 1'b0, "R1 rx_en/ovf", int'({rx_en, ovf_flag}), 0);

    // R2 other addresses
    reg_addr = 15'h0006; #1;
    chk(reg_rdata == 16'h0, "R2 other addr read", int'(reg_rdata), 0);
    wr_reg(15'h0006, 16'hFFFF);
    reg_addr = 15'h0005; #1;
    chk(reg_rdata == 16'h0002, "R2 other addr write ignored", int'(reg_rdata), 2);
    chk(rx_en == 1'b0, "R2 rx_en untouched", int'(rx_en), 0);

    // R3 receive controls, bit 0 and bit 1 kept 0
    for (int k = 0; k < 4; k++) begin
      logic [15:0] d;
      d = 16'($urandom) & 16'hFFFC;
      wr_reg(15'h0005, d);
      reg_addr = 15'h0005; #1;
      chk(reg_rdata == {11'd0, d[4:0]}, "R2 upper zero", int'(reg_rdata), int'(d[4:0]));
      chk({rx_chan, rx_src, rx_en} == d[4:2], "R3 rx bits",
          int'({rx_chan, rx_src, rx_en}), int'(d[4:2]));
    end
    wr_reg(15'h0005, 16'h0000);

    // R4/R5/R7: two bursts, final word in the stop cycle
    push(7, 1'b1);
    for (int k = 0; k < 3; k++) begin
      cyc(1'b0, 15'h0005, 16'h0, 1'b0, 16'h0);
      chk(in_ready == 1'b1, "R4 ready while loading", int'(in_ready), 1);
    end
    push(6, 1'b0);
    cyc(1'b1, 15'h0005, 16'h0003, 1'b1, 16'hA5C3);
    chk(in_ready == 1'b0, "R4 ready after stop", int'(in_ready), 0);
    play_check(3 * mlen + 2, "R7 R8 replay with stop-cycle word");

    // R11: input ignored while bit 0 is 1
    for (int k = 0; k < 5; k++) begin
      in_valid = 1'b1; #1;
      chk(in_ready == 1'b0, "R11 ready low", int'(in_ready), 0);
      cyc(1'b0, 15'h0005, 16'h0, 1'b1, 16'($urandom));
    end
    // R10: playback off, then on again from word 0
    wr_reg(15'h0005, 16'h0001);
    chk(pb_valid == 1'b0, "R10 valid off", int'(pb_valid), 0);
    tick();
    chk(pb_valid == 1'b0, "R10 valid stays off", int'(pb_valid), 0);
    wr_reg(15'h0005, 16'h0003);
    play_check(mlen + 3, "R10 R11 restart at word 0, content kept");

    // R6 overflow
    wr_reg(15'h0005, 16'h0001);
    wr_reg(15'h0005, 16'h0000);
    push(DEPTH, 1'b1);
    chk(ovf_flag == 1'b0, "R6 exactly full no ovf", int'(ovf_flag), 0);
    push(3, 1'b1);
    chk(ovf_flag == 1'b1, "R6 ovf set", int'(ovf_flag), 1);
    wr_reg(15'h0005, 16'h0003);
    chk(ovf_flag == 1'b1, "R6 ovf sticky", int'(ovf_flag), 1);
    play_check(DEPTH + 5, "R6 full replay");

    // R5: new load clears ovf
    wr_reg(15'h0005, 16'h0001);
    wr_reg(15'h0005, 16'h0000);
    chk(ovf_flag == 1'b0, "R5 ovf cleared at load start", int'(ovf_flag), 0);

    // R7 single word, only in the stop cycle
    cyc(1'b1, 15'h0005, 16'h0003, 1'b1, 16'h1357);
    play_check(4, "R7 R8 single word loop");

    // Random rounds
    for (int r = 0; r < 4; r++) begin
      wr_reg(15'h0005, 16'h0001);
      wr_reg(15'h0005, 16'h0000);
      push(1 + ($urandom % (DEPTH - 2)), 1'b0);
      cyc(1'b1, 15'h0005, 16'h0003, 1'b1, 16'($urandom));
      play_check(2 * mlen + 1, "R8 random loop");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule